// File: doc/BRIEF.md
# Multichannel Refresh Scanner with Priority Slot

This block holds one signed 16-bit output code per channel and decides which channel a downstream output engine refreshes next. Each time the engine pulses its ready strobe, the scanner hands over one channel number, that channel's stored code, and a slow flag. The slow flag asks the engine for a long settling transfer. In normal operation the scanner walks the channels in round-robin order.

A host updates codes through a write port. A write can also claim a single priority slot, so the written channel is refreshed on the next dispatch, ahead of its turn. After the priority channel is dispatched, a lockout state keeps the slot from being claimed again at once. This stops a stream of host writes from starving the round-robin walk.

The scanner counts services. When enough channels have been refreshed, or when the engine has no calibration result yet, the scanner answers a ready strobe with a calibration request instead of a dispatch.

Top module: `refresh_scanner`

## Requirements
- R1: After reset every channel holds code 0 with its slow flag set, the slot is empty, the round-robin pointer is 0, the service count is 0, and dispValid, calReq and pending are low.
- R2: With the slot not holding a channel, the dispatched channels follow the round-robin pointer 0, 1, ..., NUM_CH-1 and then wrap to 0.
- R3: An accepted write sets the channel's slow flag when the new and old codes have strictly opposite signs (zero has no sign), or when the absolute difference is at least SLOW_DELTA (default 128). Otherwise the flag keeps its previous value.
- R4: A dispatch decided at a clock edge shows up on dispValid, dispChan, dispValue and dispSlow in the cycle after that edge. The code and flag shown are the ones held before the edge, and the channel's slow flag is cleared at that edge.
- R5: An accepted write claims the slot (pending goes high) only if the slot is empty and no dispatch happens in the same cycle.
- R6: On a dispatch, a slot holding a channel dispatches that channel, leaves the pointer unchanged and becomes locked. An empty slot dispatches the pointer's channel, advances the pointer and becomes locked. A locked slot dispatches the pointer's channel, advances the pointer and becomes empty.
- R7: pending is high exactly while the slot holds a channel number; the locked state is not pending.
- R8: A write with wrChan at or above NUM_CH (NUM_CH at most 32) raises wrError in the same cycle. It stores nothing and does not claim the slot.
- R9: Every dispatch adds one to the service count. A ready strobe that arrives while the count is at or above CAL_INTERVAL (default 64), or while calValid is low, gives a one-cycle calReq in the next cycle instead of a dispatch, and clears the count.
- R10: If an accepted write and a dispatch hit the same channel in the same cycle, the dispatch carries the old code and old flag, the new code is stored, and the slow flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Host write strobe |
| wrChan | input | 5 | Channel number of the host write |
| wrValue | input | 16 | Signed code of the host write |
| wrError | output | 1 | Write rejected: channel out of range (combinational) |
| nextReady | input | 1 | Engine ready for the next service |
| calValid | input | 1 | A calibration result exists |
| dispValid | output | 1 | Dispatch outputs are valid this cycle |
| dispChan | output | 5 | Dispatched channel number |
| dispValue | output | 16 | Dispatched signed code |
| dispSlow | output | 1 | Dispatched slow-transfer flag |
| calReq | output | 1 | Calibration pass requested |
| pending | output | 1 | Slot holds a channel awaiting out-of-turn service |

## Verification
The reference model is compared on every cycle. It is driven with four kinds of input pattern:
- Plain ready strobes with no writes. These show the round-robin order and the empty/locked alternation of the slot.
- Writes placed against each slot state. These tell a correct claim apart from one made during lockout or during a dispatch cycle.
- Chosen code steps at 127, 128, a sign flip and a move away from zero. These separate each branch of the slow-flag rule.
- A long pseudo-random mix of writes, out-of-range channels and ready strobes. This also crosses the calibration interval and hits same-channel write/dispatch collisions.

// File: rtl/refresh_scanner_pkg.sv
package refresh_scanner_pkg;
  localparam int CHAN_W = 5;   // up to 32 channels
  localparam int VAL_W  = 16;  // signed output code width

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_HELD  = 2'd1,
    SLOT_LOCK  = 2'd2
  } slot_e;

  // Strobes from control to the channel register file
  typedef struct packed {
    logic                     doWrite;
    logic [CHAN_W-1:0]        wrChan;
    logic signed [VAL_W-1:0]  wrValue;
    logic                     doDispatch;
    logic [CHAN_W-1:0]        pickChan;
  } strobe_t;
endpackage

// File: rtl/refresh_scanner_regs.sv
module refresh_scanner_regs
  import refresh_scanner_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int SLOW_DELTA = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 strb,
  output logic signed [VAL_W-1:0] dispValue,
  output logic                    dispSlow
);
  localparam int DIFF_W = VAL_W + 1;

  logic signed [VAL_W-1:0] valArr  [NUM_CH];
  logic                    slowArr [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic signed [VAL_W-1:0]  chVal;
    logic                     chSlow;
    logic signed [DIFF_W-1:0] diff;
    logic        [DIFF_W-1:0] absDiff;
    logic                     signFlip;
    logic                     bigStep;
    logic                     hitWrite;
    logic                     hitDisp;

    assign hitWrite = strb.doWrite    && (strb.wrChan   == CHAN_W'(i));
    assign hitDisp  = strb.doDispatch && (strb.pickChan == CHAN_W'(i));

    always_comb begin
      diff     = DIFF_W'(strb.wrValue) - DIFF_W'(chVal);
      absDiff  = diff[DIFF_W-1] ? DIFF_W'(-diff) : DIFF_W'(diff);
      bigStep  = absDiff >= DIFF_W'(SLOW_DELTA);
      signFlip = ( strb.wrValue[VAL_W-1] && !chVal[VAL_W-1] && (chVal != '0)) ||
                 (!strb.wrValue[VAL_W-1] && (strb.wrValue != '0) && chVal[VAL_W-1]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chVal  <= '0;
        chSlow <= 1'b1;
      end else if (hitWrite) begin
        chVal  <= strb.wrValue;
        chSlow <= hitDisp | chSlow | signFlip | bigStep;
      end else if (hitDisp) begin
        chSlow <= 1'b0;
      end
    end

    assign valArr[i]  = chVal;
    assign slowArr[i] = chSlow;
  end

  logic signed [VAL_W-1:0] rdValue;
  logic                    rdSlow;

  always_comb begin
    rdValue = '0;
    rdSlow  = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (strb.pickChan == CHAN_W'(k)) begin
        rdValue = valArr[k];
        rdSlow  = slowArr[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dispValue <= '0;
      dispSlow  <= 1'b0;
    end else if (strb.doDispatch) begin
      dispValue <= rdValue;
      dispSlow  <= rdSlow;
    end
  end
endmodule

// File: rtl/refresh_scanner_ctrl.sv
module refresh_scanner_ctrl
  import refresh_scanner_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int CAL_INTERVAL = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrValid,
  input  logic [CHAN_W-1:0]       wrChan,
  input  logic signed [VAL_W-1:0] wrValue,
  input  logic                    nextReady,
  input  logic                    calValid,
  output strobe_t                 strb,
  output logic                    dispValid,
  output logic [CHAN_W-1:0]       dispChan,
  output logic                    calReq,
  output logic                    pending,
  output logic                    wrError
);
  localparam int CNT_W = $clog2(CAL_INTERVAL + 1);

  slot_e             slotState;
  logic [CHAN_W-1:0] slotChan;
  logic [CHAN_W-1:0] rrPtr;
  logic [CHAN_W-1:0] ptrNext;
  logic [CNT_W-1:0]  svcCount;

  logic wrOk, needCal, doDisp, doCal;
  logic [CHAN_W-1:0] pickChan;

  always_comb begin
    wrOk     = wrValid && ({1'b0, wrChan} < (CHAN_W+1)'(NUM_CH));
    wrError  = wrValid && !wrOk;
    needCal  = (svcCount >= CNT_W'(CAL_INTERVAL)) || !calValid;
    doDisp   = nextReady && !needCal;
    doCal    = nextReady && needCal;
    pickChan = (slotState == SLOT_HELD) ? slotChan : rrPtr;
    ptrNext  = (rrPtr == CHAN_W'(NUM_CH - 1)) ? '0 : rrPtr + 1'b1;
    pending  = (slotState == SLOT_HELD);
  end

  always_comb begin
    strb.doWrite    = wrOk;
    strb.wrChan     = wrChan;
    strb.wrValue    = wrValue;
    strb.doDispatch = doDisp;
    strb.pickChan   = pickChan;
  end

  // Priority slot and round-robin pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slotState <= SLOT_EMPTY;
      slotChan  <= '0;
      rrPtr     <= '0;
    end else if (doDisp) begin
      unique case (slotState)
        SLOT_HELD:  slotState <= SLOT_LOCK;
        SLOT_EMPTY: begin
          slotState <= SLOT_LOCK;
          rrPtr     <= ptrNext;
        end
        default: begin
          slotState <= SLOT_EMPTY;
          rrPtr     <= ptrNext;
        end
      endcase
    end else if (wrOk && (slotState == SLOT_EMPTY)) begin
      slotState <= SLOT_HELD;
      slotChan  <= wrChan;
    end
  end

  // Service counter toward calibration
  always_ff @(posedge clk) begin
    if (!rst_n)      svcCount <= '0;
    else if (doCal)  svcCount <= '0;
    else if (doDisp) svcCount <= svcCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dispValid <= 1'b0;
      dispChan  <= '0;
      calReq    <= 1'b0;
    end else begin
      dispValid <= doDisp;
      calReq    <= doCal;
      if (doDisp) dispChan <= pickChan;
    end
  end
endmodule

// File: rtl/refresh_scanner.sv
module refresh_scanner
  import refresh_scanner_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int SLOW_DELTA   = 128,
  parameter int CAL_INTERVAL = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrValid,
  input  logic [CHAN_W-1:0]       wrChan,
  input  logic signed [VAL_W-1:0] wrValue,
  output logic                    wrError,
  input  logic                    nextReady,
  input  logic                    calValid,
  output logic                    dispValid,
  output logic [CHAN_W-1:0]       dispChan,
  output logic signed [VAL_W-1:0] dispValue,
  output logic                    dispSlow,
  output logic                    calReq,
  output logic                    pending
);
  strobe_t strb;

  refresh_scanner_ctrl #(
    .NUM_CH       (NUM_CH),
    .CAL_INTERVAL (CAL_INTERVAL)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrValid   (wrValid),
    .wrChan    (wrChan),
    .wrValue   (wrValue),
    .nextReady (nextReady),
    .calValid  (calValid),
    .strb      (strb),
    .dispValid (dispValid),
    .dispChan  (dispChan),
    .calReq    (calReq),
    .pending   (pending),
    .wrError   (wrError)
  );

  refresh_scanner_regs #(
    .NUM_CH     (NUM_CH),
    .SLOW_DELTA (SLOW_DELTA)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .dispValue (dispValue),
    .dispSlow  (dispSlow)
  );
endmodule

// File: rtl/refresh_scanner_checker.sv
module refresh_scanner_checker #(
  parameter int NUM_CH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wrValid,
  input logic        wrError,
  input logic        nextReady,
  input logic        dispValid,
  input logic [4:0]  dispChan,
  input logic        calReq,
  input logic        pending
);
  assert_cal_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(calReq && dispValid));

  assert_disp_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |-> $past(nextReady));

  assert_no_pend_after_disp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |-> !pending);

  assert_reject_noclaim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrError && !pending) |=> !pending);

  assert_chan_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dispValid |-> (32'(dispChan) < NUM_CH));

  assert_claim_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(wrValid && !wrError));
endmodule

bind refresh_scanner refresh_scanner_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wrValid   (wrValid),
  .wrError   (wrError),
  .nextReady (nextReady),
  .dispValid (dispValid),
  .dispChan  (dispChan),
  .calReq    (calReq),
  .pending   (pending)
);

// File: tb/refresh_scanner_test.sv
module refresh_scanner_test;
  localparam int NCH = 4;
  localparam int DELTA = 128;
  localparam int INTERVAL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrValid = 1'b0;
  logic [4:0] wrChan = '0;
  logic signed [15:0] wrValue = '0;
  logic nextReady = 1'b0;
  logic calValid = 1'b0;
  logic wrError, dispValid, dispSlow, calReq, pending;
  logic [4:0] dispChan;
  logic signed [15:0] dispValue;

  always #2 clk = ~clk;

  refresh_scanner #(.NUM_CH(NCH), .SLOW_DELTA(DELTA), .CAL_INTERVAL(INTERVAL)) uut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrChan(wrChan), .wrValue(wrValue),
    .wrError(wrError), .nextReady(nextReady), .calValid(calValid),
    .dispValid(dispValid), .dispChan(dispChan), .dispValue(dispValue),
    .dispSlow(dispSlow), .calReq(calReq), .pending(pending)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model: slot -1 empty, -2 locked, otherwise channel number
  int mVal [NCH];
  bit mSlow [NCH];
  int mSlot, mPtr, mCount;
  int seed = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic int nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NCH; i++) begin
      mVal[i] = 0;
      mSlow[i] = 1;
    end
    mSlot = -1; mPtr = 0; mCount = 0;
  endtask

  // One cycle: drive after a falling edge, check, advance model, compare
  task automatic tick(input bit wv, input int wc, input int wval, input bit rdy);
    bit needCal, eDisp, eCal, wOk, eSlowOut, nSlow;
    int ch, eValOut, old, diff;
    wrValid = wv; wrChan = wc[4:0]; wrValue = wval[15:0]; nextReady = rdy;
    #1;
    check(wrError === (wv && wc >= NCH), "R8 wrError", int'(wrError), int'(wv && wc >= NCH));
    check(pending === (mSlot >= 0), "R7 R5 R6 pending", int'(pending), int'(mSlot >= 0));
    needCal = (mCount >= INTERVAL) || !calValid;
    eDisp = rdy && !needCal;
    eCal = rdy && needCal;
    wOk = wv && (wc < NCH);
    ch = 0; eValOut = 0; eSlowOut = 0;
    @(posedge clk);
    if (eDisp) begin
      ch = (mSlot >= 0) ? mSlot : mPtr;
      eValOut = mVal[ch];
      eSlowOut = mSlow[ch];
      mSlow[ch] = 0;
      if (mSlot >= 0) mSlot = -2;
      else begin
        mSlot = (mSlot == -1) ? -2 : -1;
        mPtr = (mPtr + 1) % NCH;
      end
      mCount++;
    end
    if (eCal) mCount = 0;
    if (wOk) begin
      old = mVal[wc];
      diff = wval - old;
      if (diff < 0) diff = -diff;
      if (eDisp && ch == wc) nSlow = 1;
      else nSlow = mSlow[wc] || (wval < 0 && old > 0) || (wval > 0 && old < 0) || (diff >= DELTA);
      mVal[wc] = wval;
      mSlow[wc] = nSlow;
      if (!eDisp && mSlot == -1) mSlot = wc;
    end
    @(negedge clk);
    check(dispValid === eDisp, "R9 R4 dispValid", int'(dispValid), int'(eDisp));
    check(calReq === eCal, "R9 calReq", int'(calReq), int'(eCal));
    if (eDisp) begin
      check(int'(dispChan) == ch, "R2 R5 R6 dispChan", int'(dispChan), ch);
      check(int'(dispValue) == eValOut, "R3 R4 R10 dispValue", int'(dispValue), eValOut);
      check(dispSlow === eSlowOut, "R1 R3 R4 R10 dispSlow", int'(dispSlow), int'(eSlowOut));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(dispValid === 1'b0, "R1 dispValid", int'(dispValid), 0);
    check(calReq === 1'b0, "R1 calReq", int'(calReq), 0);
    check(pending === 1'b0, "R1 pending", int'(pending), 0);
    rst_n = 1'b1;

    // R9: no calibration result yet -> request instead of dispatch
    tick(0, 0, 0, 1);
    calValid = 1'b1;
    // R1 R2: reset codes with slow set, round-robin with wrap
    for (int i = 0; i < 5; i++) tick(0, 0, 0, 1);
    // slot now locked: this write must not claim (R6 lockout)
    tick(1, 2, 50, 0);
    check(pending === 1'b0, "R6 lockout blocks claim", int'(pending), 0);
    tick(0, 0, 0, 1);            // locked -> empty
    tick(1, 1, 300, 0);          // claims slot (R5)
    tick(0, 0, 0, 1);            // channel 1 out of turn, slow from step
    tick(0, 0, 0, 1);            // locked -> empty, round-robin
    // R3 slow-rule steps on channel 3 (slot busy so no claim noise)
    tick(1, 3, 10, 1);
    tick(1, 3, 137, 0);          // step 127
    tick(1, 3, 265, 0);          // step 128
    tick(1, 3, -5, 0);           // sign flip
    for (int i = 0; i < 6; i++) tick(0, 0, 0, 1);
    tick(1, 0, 0, 0);
    tick(1, 0, -20, 0);          // from zero: no strict flip
    // R8: out-of-range writes
    tick(1, 7, 99, 0);
    tick(1, 31, -99, 0);
    tick(1, 4, 1, 1);
    // R10: claim channel 2 then write it during its dispatch
    while (mSlot != -1) tick(0, 0, 0, 1);
    tick(1, 2, 40, 0);
    tick(1, 2, 45, 1);
    tick(0, 0, 0, 1);
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 1);
    // R9: run past the calibration interval
    for (int i = 0; i < 80; i++) tick(0, 0, 0, 1);
    // Pseudo-random mix
    for (int i = 0; i < 1500; i++) begin
      int r, r2, wc, wv;
      r = nextRand();
      r2 = nextRand();
      wc = r[7] ? int'(r[6:2]) : int'(r[3:2]);
      if (r[12]) wv = int'($signed(r2[15:0]));
      else wv = int'($signed(r2[8:0]));
      if (i % 200 == 150) calValid = 1'b0;
      if (i % 200 == 155) calValid = 1'b1;
      tick(r[0] & r[1], wc, wv, r[8] | r[9]);
    end
    summary();
  end
endmodule